// File: doc/BRIEF.md
# Slot-Timing Tick Divider

This block derives a slow timing enable, nominally one pulse per microsecond, from a system clock of any frequency in the supported range. A host writes one configuration byte. The byte carries an enable flag, a power-of-two prescale exponent and a two-bit selector for an odd base multiplier. The block then emits a one-cycle `tick` pulse once every `multiplier × prescale` clock cycles. Downstream slot-timing logic uses `tick` as a clock enable.

Two counters are cascaded to do the division. A prescale counter wraps every 2^n cycles. An odd counter advances on each prescale wrap and completes after 1, 3, 5 or 7 of those wraps. Each configuration write restarts both counters, so the phase of the tick stream is known from the write onward. The `active` output tells the host that the divided timing base has produced its first pulse since the last write.

For example, a 24 MHz clock uses multiplier 3 and prescale 8, which is byte 0x8D. A 128 MHz clock uses multiplier 1 and prescale 128, which is byte 0x9C.

Top module: `tick_divider`

## Requirements
- R1: After reset, `tick` and `active` are 0 and the divider is disabled.
- R2: When bit 7 of the configuration byte is 0, `tick` and `active` stay 0 and both counters stay at zero.
- R3: Bits 1:0 select the base multiplier: code 0 gives 1, 1 gives 3, 2 gives 5 and 3 gives 7.
- R4: Bits 4:2 hold an exponent n from 0 to 7, and the prescale is 2^n.
- R5: When enabled with total division D = multiplier × prescale, `tick` is high for exactly one cycle in every D cycles. At D = 1 it is high in every cycle.
- R6: A configuration write restarts the division. If the write is sampled at a clock edge, `tick` is high in the D-th cycle after that edge and in every D-th cycle after that.
- R7: Every configuration write clears `active`. `active` then goes high in the cycle after the first `tick` that follows the write, and it stays high until the next write.
- R8: Bits 6:5 of the configuration byte have no effect on `tick` or `active`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_we | input | 1 | Write strobe for the configuration byte |
| cfg_wdata | input | 8 | Configuration byte: bit 7 enable, bits 4:2 prescale exponent, bits 1:0 multiplier selector |
| tick | output | 1 | One-cycle timing pulse |
| active | output | 1 | Set once the timing base has produced its first tick since the last write |

## Verification
The assertions check, on every cycle, the invariants that hold regardless of history:
- Both counters stay within the limits decoded from the configuration.
- The divider is silent and the counters are zeroed while it is disabled.
- A write returns both counters to zero and clears `active`.
- `active` rises only after a tick.

Some properties need the counted spacing between pulses over many cycles. These are the exact period for every setting, the phase of the first tick after a write, and the fact that the spare bits do nothing. Only the bench shows them, by sweeping all 32 enabled settings and comparing each cycle against a period computed arithmetically.

// File: rtl/tickdiv_pkg.sv
package tickdiv_pkg;

  parameter int unsigned CFG_W   = 8;
  parameter int unsigned EN_BIT  = 7;
  parameter int unsigned EXP_W   = 3;   // prescale exponent width
  parameter int unsigned SEL_W   = 2;   // odd multiplier selector width
  parameter int unsigned EXP_LSB = SEL_W;

  // Prescale counter must reach 2^(2^EXP_W - 1) - 1.
  localparam int unsigned PRE_CNT_W = (1 << EXP_W) - 1;
  // Largest odd multiplier is 2*2^SEL_W - 1.
  localparam int unsigned ODD_CNT_W = SEL_W + 1;

  typedef struct packed {
    logic             en;
    logic [EXP_W-1:0] exp_sel;
    logic [SEL_W-1:0] mul_sel;
  } tickdiv_cfg_t;

  function automatic tickdiv_cfg_t decode_cfg(input logic [CFG_W-1:0] raw);
    tickdiv_cfg_t c;
    c.en      = raw[EN_BIT];
    c.exp_sel = raw[EXP_LSB +: EXP_W];
    c.mul_sel = raw[0 +: SEL_W];
    return c;
  endfunction

  // Terminal count of the prescaler: 2^exp - 1, built as a thermometer.
  function automatic logic [PRE_CNT_W-1:0] pre_limit(input logic [EXP_W-1:0] e);
    logic [PRE_CNT_W-1:0] l;
    for (int i = 0; i < PRE_CNT_W; i++) l[i] = (i < int'(e));
    return l;
  endfunction

  // Terminal count of the odd counter: multiplier - 1 = 2*sel.
  function automatic logic [ODD_CNT_W-1:0] odd_limit(input logic [SEL_W-1:0] s);
    return {s, 1'b0};
  endfunction

endpackage

// File: rtl/tickdiv_cfg_reg.sv
module tickdiv_cfg_reg
  import tickdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  output tickdiv_cfg_t     cfg
);

  tickdiv_cfg_t cfg_d, cfg_q;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en) cfg_d = decode_cfg(wr_data);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  assign cfg = cfg_q;

endmodule

// File: rtl/tickdiv_prescaler.sv
module tickdiv_prescaler
  import tickdiv_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 restart,
  input  logic [EXP_W-1:0]     exp_sel,
  output logic                 wrap,
  output logic [PRE_CNT_W-1:0] cnt
);

  logic [PRE_CNT_W-1:0] cnt_d, cnt_q, limit;
  logic                 at_end;

  assign limit  = pre_limit(exp_sel);
  assign at_end = (cnt_q == limit);

  always_comb begin
    cnt_d = cnt_q;
    if (restart || !en) cnt_d = '0;
    else if (at_end)    cnt_d = '0;
    else                cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign wrap = en && at_end;
  assign cnt  = cnt_q;

endmodule

// File: rtl/tickdiv_odd_counter.sv
module tickdiv_odd_counter
  import tickdiv_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 restart,
  input  logic                 step,
  input  logic [SEL_W-1:0]     mul_sel,
  output logic                 done,
  output logic [ODD_CNT_W-1:0] cnt
);

  logic [ODD_CNT_W-1:0] cnt_d, cnt_q, limit;
  logic                 at_end;

  assign limit  = odd_limit(mul_sel);
  assign at_end = (cnt_q == limit);

  always_comb begin
    cnt_d = cnt_q;
    if (restart || !en) cnt_d = '0;
    else if (step)      cnt_d = at_end ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = en && step && at_end;
  assign cnt  = cnt_q;

endmodule

// File: rtl/tick_divider.sv
module tick_divider
  import tickdiv_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [7:0] cfg_wdata,
  output logic       tick,
  output logic       active
);

  tickdiv_cfg_t         cfg;
  logic                 pre_wrap;
  logic                 odd_done;
  logic [PRE_CNT_W-1:0] pre_cnt;
  logic [ODD_CNT_W-1:0] odd_cnt;
  logic                 active_d, active_q;

  tickdiv_cfg_reg u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_we),
    .wr_data (cfg_wdata),
    .cfg     (cfg)
  );

  tickdiv_prescaler u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (cfg.en),
    .restart (cfg_we),
    .exp_sel (cfg.exp_sel),
    .wrap    (pre_wrap),
    .cnt     (pre_cnt)
  );

  tickdiv_odd_counter u_odd (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (cfg.en),
    .restart (cfg_we),
    .step    (pre_wrap),
    .mul_sel (cfg.mul_sel),
    .done    (odd_done),
    .cnt     (odd_cnt)
  );

  // A write takes priority over a coincident tick.
  always_comb begin
    active_d = active_q;
    if (cfg_we)        active_d = 1'b0;
    else if (odd_done) active_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active_q <= 1'b0;
    else        active_q <= active_d;
  end

  assign tick   = odd_done;
  assign active = active_q;

endmodule

// File: rtl/tick_divider_checker.sv
module tick_divider_checker
  import tickdiv_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cfg_we,
  input logic                 tick,
  input logic                 active,
  input tickdiv_cfg_t         cfg,
  input logic [PRE_CNT_W-1:0] pre_cnt,
  input logic [ODD_CNT_W-1:0] odd_cnt
);

  // R2: disabled divider is silent
  a_r2_no_tick_off: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.en |-> !tick && !active);

  // R2: counters held at zero while disabled
  a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.en |-> (pre_cnt == '0) && (odd_cnt == '0));

  // R4: prescale counter stays below 2^n
  a_r4_pre_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pre_cnt) < (1 << int'(cfg.exp_sel)));

  // R3: odd counter stays below the multiplier
  a_r3_odd_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(odd_cnt) < 2 * int'(cfg.mul_sel) + 1);

  // R6: a write restarts both counters
  a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (pre_cnt == '0) && (odd_cnt == '0));

  // R7: a write clears the running flag
  a_r7_write_clear: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> !active);

  // R7: the flag rises only after a tick
  a_r7_rise_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> $past(tick));

endmodule

bind tick_divider tick_divider_checker u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cfg_we  (cfg_we),
  .tick    (tick),
  .active  (active),
  .cfg     (cfg),
  .pre_cnt (pre_cnt),
  .odd_cnt (odd_cnt)
);

// File: tb/tick_divider_tb.sv
module tick_divider_tb;

  logic       clk;
  logic       rst_n;
  logic       cfg_we;
  logic [7:0] cfg_wdata;
  logic       tick;
  logic       active;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  tick_divider u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .tick      (tick),
    .active    (active)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic int div_of(input logic [7:0] v);
    int mul = 2 * int'(v[1:0]) + 1;
    int pre = 1 << int'(v[4:2]);
    return mul * pre;
  endfunction

  // Write v, then compare tick/active for n cycles against the period model.
  // Returns with the bench at the negedge of cycle n.
  task automatic run_window(input logic [7:0] v, input int n, input string tag);
    int  d   = div_of(v);
    bit  en  = v[7];
    int  bad = 0;
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    for (int j = 1; j <= n; j++) begin
      logic et, ea;
      if (j > 1) @(negedge clk);
      et = en && (j % d == 0);
      ea = en && (j > d);
      if ((tick !== et || active !== ea) && bad == 0)
        $display("FAIL %s cfg=%02h cycle %0d: tick=%b active=%b expected tick=%b active=%b",
                 tag, v, j, tick, active, et, ea);
      if (tick !== et || active !== ea) bad++;
    end
    checks++;
    if (bad != 0) errors++;
  endtask

  initial begin
    cfg_we = 1'b0; cfg_wdata = '0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (tick !== 1'b0 || active !== 1'b0) begin
      errors++;
      $display("FAIL R1 tick=%b active=%b expected 0 0", tick, active);
    end
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    checks++;
    if (tick !== 1'b0 || active !== 1'b0) begin
      errors++;
      $display("FAIL R1 idle after reset tick=%b active=%b expected 0 0", tick, active);
    end

    // R3: multiplier 7 alone, prescale 1
    run_window(8'h83, 30, "R3");
    // R4: prescale 128, multiplier 1
    run_window(8'h9C, 300, "R4");
    // R5: divide by one ticks every cycle
    run_window(8'h80, 10, "R5");
    // R6: rewrite in the middle of a long period restarts the phase
    run_window(8'h8D, 10, "R6");
    run_window(8'h8D, 60, "R6");
    // R7: flag cleared by write and set again after the first tick
    run_window(8'h8C, 40, "R7");
    // R8: spare bits 6:5 ignored
    run_window(8'hE1, 20, "R8");
    run_window(8'hA9, 100, "R8");
    // R2: disabled setting, then disable after running
    run_window(8'h1F, 400, "R2");
    run_window(8'h82, 20, "R2");
    run_window(8'h00, 100, "R2");

    // R5 sweep over every enabled setting (R3 and R4 combined)
    for (int c = 0; c < 32; c++) begin
      logic [7:0] v = 8'h80 | 8'(c);
      run_window(v, 2 * div_of(v) + 3, "R5");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule